// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit keeps the eight-bit status word of a serial flash device and decides whether writes are permitted. It keeps the write-enable latch, four block-protect bits and a lock bit. The lock bit takes effect only while the active-low write-protect pin is held low. The serial command decoder sends it one-cycle pulses for write enable, write disable, enable-status-write, status write (with its data byte), other commands, and completion of a program or erase.

The protect bits are decoded into a region that starts at the top of the address space and grows downward. Any address presented on the query port is answered at once with whether it falls inside that region. A separate output reports whether a whole-chip erase is currently permitted. The size of the address space is a parameter, so the protected fractions always map onto the array's own top address.

Top module: `wp_status_unit`

## Requirements
- R1: After reset the status word reads 0x1C: protect bits [4:2] are 1, protect bit 5 is 0, and the lock (bit 7) and the write-enable latch (bit 1) are 0. This assumes busy and auto-increment inputs are 0.
- R2: Status bit 0 follows the busy input and bit 6 follows the auto-increment input. Bits 0, 1 and 6 are never changed by a status write; the data byte supplies only bits 5:2 and bit 7.
- R3: A write-enable pulse sets the latch (bit 1). A write-disable pulse or an operation-done pulse clears it.
- R4: A status write is armed only when the command pulse just before it was write-enable or enable-status-write. Any other command pulse between them disarms it, and the status write then leaves bits 7:2 unchanged.
- R5: An armed status write is refused exactly when the write-protect pin is low and the lock bit is 1. While the pin is high the lock is ignored, and a write may clear it.
- R6: While the pin is low and the lock is 0, one armed write can set the lock and change the protect bits together. Later writes are refused while the pin stays low.
- R7: Let L be protect bits [2:0] (status bits 4:2). For L = 1, 2, 3, 4 the protected region is the top 1/16, 1/8, 1/4 or 1/2 of the address space. L = 0 protects nothing. Protect bit 3 (status bit 5) has no effect on the region.
- R8: For L = 5, 6 or 7 every address is protected.
- R9: Chip erase is reported as permitted only when all four protect bits (status bits 5:2) are 0.
- R10: Every status-write pulse clears the write-enable latch and disarms, whether the write was accepted or refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Internal operation in progress (status bit 0) |
| aai_i | input | 1 | Auto-increment programming active (status bit 6) |
| wren_i | input | 1 | Write-enable command pulse |
| wrdi_i | input | 1 | Write-disable command pulse |
| ewsr_i | input | 1 | Enable-status-write command pulse |
| wrsr_i | input | 1 | Status-write command pulse |
| wrsr_data_i | input | 8 | Data byte carried by the status write |
| other_cmd_i | input | 1 | Pulse for any other decoded command |
| op_done_i | input | 1 | Program or erase completed |
| query_addr_i | input | ADDR_W | Address whose protection is queried |
| status_o | output | 8 | Status word |
| addr_prot_o | output | 1 | Queried address lies in the protected region |
| chip_erase_ok_o | output | 1 | Whole-chip erase permitted |

## Verification
The hardest state to reach is a refused write: the lock must first be set through an accepted write, and then the pin has to drop before a freshly armed write. The stimulus does this in both orders. It sets the lock with the pin high and then lowers the pin. It also sets the lock with the pin already low, in a single write that changes the protect bits at the same time. After that, the bench writes all sixteen protect codes and checks every address of a 64-entry configuration against boundaries it computes from the fraction each code selects.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;

    localparam int SR_W     = 8;
    localparam int BP_W     = 4;
    localparam int LVL_W    = 3;
    localparam int BUSY_POS = 0;
    localparam int WEL_POS  = 1;
    localparam int BP_LSB   = 2;
    localparam int AAI_POS  = 6;
    localparam int LOCK_POS = 7;
    localparam int MAX_FRAC_LVL = 4;

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] bp;
        logic            wel;
        logic            armed;
    } sr_state_t;

    localparam sr_state_t SR_RESET = '{
        lock:  1'b0,
        bp:    4'b0111,
        wel:   1'b0,
        armed: 1'b0
    };

endpackage

// File: rtl/wp_sr_core.sv
module wp_sr_core
    import wp_status_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wp_ni,
    input  logic            wren_i,
    input  logic            wrdi_i,
    input  logic            ewsr_i,
    input  logic            wrsr_i,
    input  logic [SR_W-1:0] wrsr_data_i,
    input  logic            other_cmd_i,
    input  logic            op_done_i,
    output sr_state_t       state_o
);

    sr_state_t state_d, state_q;
    logic      write_ok;

    logic unused_data;
    assign unused_data = ^{wrsr_data_i[AAI_POS], wrsr_data_i[WEL_POS], wrsr_data_i[BUSY_POS]};

    always_comb begin
        state_d  = state_q;
        write_ok = state_q.armed && !(!wp_ni && state_q.lock);

        if (wren_i) begin
            state_d.wel   = 1'b1;
            state_d.armed = 1'b1;
        end
        if (ewsr_i) begin
            state_d.armed = 1'b1;
        end
        if (other_cmd_i || wrdi_i) begin
            state_d.armed = 1'b0;
        end
        if (wrdi_i || op_done_i) begin
            state_d.wel = 1'b0;
        end
        if (wrsr_i) begin
            if (write_ok) begin
                state_d.bp   = wrsr_data_i[BP_LSB +: BP_W];
                state_d.lock = wrsr_data_i[LOCK_POS];
            end
            state_d.wel   = 1'b0;
            state_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/wp_prot_decode.sv
module wp_prot_decode
    import wp_status_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [BP_W-1:0]   bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o,
    output logic              erase_ok_o
);

    localparam int TOP_BITS = MAX_FRAC_LVL;

    logic [LVL_W-1:0]        lvl;
    logic [MAX_FRAC_LVL:1]   lvl_hit;

    assign lvl = bp_i[LVL_W-1:0];

    // Level k protects the top 2^-(5-k) of memory: the upper (5-k) address bits all ones.
    for (genvar k = 1; k <= MAX_FRAC_LVL; k++) begin : g_lvl
        localparam int NBITS = TOP_BITS + 1 - k;
        assign lvl_hit[k] = &addr_i[ADDR_W-1 -: NBITS];
    end

    always_comb begin
        prot_o = 1'b1;
        if (lvl == '0) begin
            prot_o = 1'b0;
        end else if (lvl <= LVL_W'(MAX_FRAC_LVL)) begin
            prot_o = lvl_hit[lvl];
        end
    end

    assign erase_ok_o = (bp_i == '0);

endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
    import wp_status_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wp_ni,
    input  logic              busy_i,
    input  logic              aai_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              ewsr_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              other_cmd_i,
    input  logic              op_done_i,
    input  logic [ADDR_W-1:0] query_addr_i,
    output logic [7:0]        status_o,
    output logic              addr_prot_o,
    output logic              chip_erase_ok_o
);

    sr_state_t state;

    wp_sr_core u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wp_ni       (wp_ni),
        .wren_i      (wren_i),
        .wrdi_i      (wrdi_i),
        .ewsr_i      (ewsr_i),
        .wrsr_i      (wrsr_i),
        .wrsr_data_i (wrsr_data_i),
        .other_cmd_i (other_cmd_i),
        .op_done_i   (op_done_i),
        .state_o     (state)
    );

    wp_prot_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bp_i       (state.bp),
        .addr_i     (query_addr_i),
        .prot_o     (addr_prot_o),
        .erase_ok_o (chip_erase_ok_o)
    );

    always_comb begin
        status_o                     = '0;
        status_o[BUSY_POS]           = busy_i;
        status_o[WEL_POS]            = state.wel;
        status_o[BP_LSB +: BP_W]     = state.bp;
        status_o[AAI_POS]            = aai_i;
        status_o[LOCK_POS]           = state.lock;
    end

endmodule

// File: rtl/wp_status_checker.sv
module wp_status_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wp_ni,
    input logic       wren_i,
    input logic       wrdi_i,
    input logic       wrsr_i,
    input logic       op_done_i,
    input logic [7:0] status_o,
    input logic       addr_prot_o,
    input logic       chip_erase_ok_o
);

    p_bp_only_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrsr_i |=> $stable(status_o[7:2]));

    p_locked_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wp_ni && status_o[7]) |=> $stable(status_o[7:2]));

    p_wel_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrdi_i || op_done_i) |=> !status_o[1]);

    p_wel_clear_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrsr_i |=> !status_o[1]);

    p_wel_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wren_i && !wrdi_i && !op_done_i && !wrsr_i) |=> status_o[1]);

    p_full_prot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[4] && (status_o[3] || status_o[2])) |-> addr_prot_o);

    p_erase_safe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chip_erase_ok_o |-> !addr_prot_o);

endmodule

bind wp_status_unit wp_status_checker u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wp_ni           (wp_ni),
    .wren_i          (wren_i),
    .wrdi_i          (wrdi_i),
    .wrsr_i          (wrsr_i),
    .op_done_i       (op_done_i),
    .status_o        (status_o),
    .addr_prot_o     (addr_prot_o),
    .chip_erase_ok_o (chip_erase_ok_o)
);

// File: tb/tb_wp_status_unit.sv
module tb_wp_status_unit;

    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          busy = 1'b0, aai = 1'b0;
    logic          wren = 1'b0, wrdi = 1'b0, ewsr = 1'b0, wrsr = 1'b0;
    logic [7:0]    wdata = '0;
    logic          other = 1'b0, done = 1'b0;
    logic [AW-1:0] qaddr = '0;
    logic [7:0]    status;
    logic          prot, ce_ok;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    wp_status_unit #(.ADDR_W(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .busy_i(busy), .aai_i(aai),
        .wren_i(wren), .wrdi_i(wrdi), .ewsr_i(ewsr), .wrsr_i(wrsr),
        .wrsr_data_i(wdata), .other_cmd_i(other), .op_done_i(done),
        .query_addr_i(qaddr), .status_o(status), .addr_prot_o(prot),
        .chip_erase_ok_o(ce_ok)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_wren();  @(negedge clk); wren = 1; @(negedge clk); wren = 0; endtask
    task automatic pulse_wrdi();  @(negedge clk); wrdi = 1; @(negedge clk); wrdi = 0; endtask
    task automatic pulse_ewsr();  @(negedge clk); ewsr = 1; @(negedge clk); ewsr = 0; endtask
    task automatic pulse_other(); @(negedge clk); other = 1; @(negedge clk); other = 0; endtask
    task automatic pulse_done();  @(negedge clk); done = 1; @(negedge clk); done = 0; endtask
    task automatic pulse_wrsr(input logic [7:0] d);
        @(negedge clk); wrsr = 1; wdata = d; @(negedge clk); wrsr = 0; wdata = '0;
    endtask

    function automatic logic exp_prot(input int code, input int a);
        int lvl;
        lvl = code & 7;
        if (lvl == 0) return 1'b0;
        if (lvl >= 5) return 1'b1;
        return (a >= N - (N >> (5 - lvl)));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", status, 8'h1C);
        qaddr = '0; #1;
        check("R8 reset full protect", {7'b0, prot}, 8'h01);
        check("R9 reset erase", {7'b0, ce_ok}, 8'h00);

        // R2 read-only bits
        busy = 1; aai = 1; #1;
        check("R2 busy/aai", status, 8'h5D);
        busy = 0; aai = 0;
        pulse_wren();
        pulse_wrsr(8'hFF);
        check("R2 ro bits not written", status, 8'hBC);

        // R3 latch
        pulse_wren();
        check("R3 wel set", {7'b0, status[1]}, 8'h01);
        pulse_wrdi();
        check("R3 wel clr wrdi", {7'b0, status[1]}, 8'h00);
        pulse_wren();
        pulse_done();
        check("R3 wel clr done", {7'b0, status[1]}, 8'h00);

        // R4 arming
        pulse_wren();
        pulse_other();
        pulse_wrsr(8'h00);
        check("R4 disarmed write", status, 8'hBC);
        pulse_wrsr(8'h00);
        check("R4 no arm", status, 8'hBC);
        pulse_ewsr();
        pulse_wrsr(8'h00);
        check("R4 ewsr armed", status, 8'h00);
        check("R9 erase ok", {7'b0, ce_ok}, 8'h01);

        // R5 lock with pin
        pulse_wren();
        pulse_wrsr(8'h88);
        check("R5 lock set pin high", status, 8'h88);
        wp_n = 0;
        pulse_wren();
        check("R3 wel while locked", status, 8'h8A);
        pulse_wrsr(8'h00);
        check("R5 refused", status[7:2], 8'h22);
        check("R10 wel cleared on refused", {7'b0, status[1]}, 8'h00);
        wp_n = 1;
        pulse_wren();
        pulse_wrsr(8'h00);
        check("R5 pin high clears lock", status, 8'h00);

        // R6 single write sets lock and bits with pin low
        wp_n = 0;
        pulse_ewsr();
        pulse_wrsr(8'h94);
        check("R6 lock+bp", status, 8'h94);
        pulse_ewsr();
        pulse_wrsr(8'h00);
        check("R6 locked afterwards", status, 8'h94);
        wp_n = 1;

        // R7 R8 R9 sweep
        for (int code = 0; code < 16; code++) begin
            pulse_wren();
            pulse_wrsr(8'(code << 2));
            check("R7 bp written", {4'b0, status[5:2]}, 8'(code));
            check("R9 erase gate", {7'b0, ce_ok}, {7'b0, code == 0});
            for (int a = 0; a < N; a++) begin
                qaddr = AW'(a); #1;
                if ((code & 7) >= 5)
                    check("R8 full", {7'b0, prot}, 8'h01);
                else
                    check("R7 region", {7'b0, prot}, {7'b0, exp_prot(code, a)});
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule